// File: doc/BRIEF.md
# Option Protection Register with Key Unlock and Timed Commit

This block holds the non-volatile option settings of an embedded flash controller: a readout-protection level, one write-protect bit per sector and a small set of user option bits. Software reaches it through a simple register bus with two addresses. One is a key register that takes a two-word unlock sequence. The other is an option control register that packs all fields with a lock bit and a start bit.

After unlocking, software writes new field values, which stay pending. Setting the start bit commits them. The block then holds `busy` for a fixed number of cycles, which models the non-volatile write. When `busy` drops, the committed values drive the outputs. These are the active-high per-sector protect vector for the program/erase sequencer, the readout-protected flag and the committed user bits. Writing the lock bit closes the register again.

The register bus is a control path, not a data stream, so it has no back-pressure. A write takes effect at the clock edge where `bus_wr` is sampled. A read strobe is always answered one cycle later with `bus_rvalid` high for one cycle.

Top module: `optreg_top`

## Requirements
- R1: After reset the register is locked, the pending and committed level is 0xAA, every write-protect field bit is 1 (no sector protected), the user bits are 0, `busy` is 0, `rdp_active` is 0 and `sect_wp` is all 0.
- R2: Writing 0x08192A3B and then 0x4C5D6E7F as two consecutive writes to the key address (offset 0x04) clears the lock bit (control bit 0).
- R3: A key-address write that breaks the sequence returns it to the start. A wrong second word, or a first word alone, leaves the register locked.
- R4: While locked, writes to the control address (offset 0x08) change neither the fields nor `busy`.
- R5: A control read returns the lock bit in bit 0, `busy` in bit 1, the user bits in bits 7:0, the readout level in bits 15:8 and the sector write-protect field in bits 27:16 (bit 16 is sector 0). The rest read 0.
- R6: Only the user bits under mask 0xEC are stored. The other low-byte bits read back as 0.
- R7: A field write with bit 1 set and bit 0 clear starts a commit. `busy` is then high for exactly COMMIT_CYCLES cycles, and the outputs take the new values in the cycle `busy` falls.
- R8: Pending field values that are not yet committed, or whose commit is still running, do not change `sect_wp`, `rdp_active` or `user_opts`.
- R9: `rdp_active` is 0 only when the committed level is exactly 0xAA. Any other level, including 0xAB, sets it.
- R10: A 0 in write-protect field bit i makes `sect_wp[i]` 1 after commit. A 1 makes it 0.
- R11: A control write with bit 0 set relocks the register and leaves every field unchanged.
- R12: While `busy` is high, control writes are ignored, including a lock request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read strobe |
| busy | output | 1 | Commit in progress |
| sect_wp | output | NUM_SECTORS | Committed protect flags, 1 = sector protected |
| rdp_active | output | 1 | Committed readout protection is on |
| user_opts | output | 8 | Committed user option bits |

## Verification
The assertions assume that reset is held low for at least one clock edge and that `bus_wr` and `bus_rd` are never high in the same cycle. They also assume the bus only addresses the key and control offsets when it expects an effect. The bench tasks each raise exactly one strobe for one cycle on a falling edge, always use one of the two defined offsets, and space reads and writes so that no two accesses share a cycle. Lock requests and key words are issued during a running commit on purpose, because the checks rely on these inputs being legal at any time.

// File: rtl/optreg_pkg.sv
package optreg_pkg;
  localparam int          DATA_W      = 32;
  localparam int          LOCK_BIT    = 0;
  localparam int          START_BIT   = 1;
  localparam int          LVL_LSB     = 8;
  localparam int          WP_LSB      = 16;
  localparam int          WP_FIELD_W  = 12;
  localparam logic [7:0]  USER_MASK   = 8'hEC;
  localparam logic [7:0]  LVL_OPEN    = 8'hAA;
  localparam logic [31:0] KEY_FIRST   = 32'h0819_2A3B;
  localparam logic [31:0] KEY_SECOND  = 32'h4C5D_6E7F;

  typedef enum logic {KS_WANT_FIRST, KS_WANT_SECOND} keyseq_t;
endpackage

// File: rtl/optreg_keyseq.sv
module optreg_keyseq
  import optreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              relock,
  output logic              locked
);
  keyseq_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      st_q   <= KS_WANT_FIRST;
    end else if (relock) begin
      locked <= 1'b1;
      st_q   <= KS_WANT_FIRST;
    end else if (key_wr && locked) begin
      case (st_q)
        KS_WANT_FIRST: begin
          if (key_data == KEY_FIRST) st_q <= KS_WANT_SECOND;
        end
        KS_WANT_SECOND: begin
          st_q <= KS_WANT_FIRST;
          if (key_data == KEY_SECOND) locked <= 1'b0;
        end
        default: st_q <= KS_WANT_FIRST;
      endcase
    end
  end
endmodule

// File: rtl/optreg_commit.sv
module optreg_commit
  import optreg_pkg::*;
#(
  parameter int NUM_SECTORS   = 12,
  parameter int COMMIT_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NUM_SECTORS-1:0] pend_wp,
  input  logic [7:0]             pend_lvl,
  input  logic [7:0]             pend_user,
  output logic                   busy,
  output logic [NUM_SECTORS-1:0] shadow_wp,
  output logic [7:0]             shadow_lvl,
  output logic [7:0]             shadow_user
);
  localparam int CNT_W = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(COMMIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // Pending fields cannot change while busy, so they are sampled at the end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt_q       <= '0;
      shadow_wp   <= '1;
      shadow_lvl  <= LVL_OPEN;
      shadow_user <= 8'h00;
    end else if (busy) begin
      if (cnt_q == '0) begin
        busy        <= 1'b0;
        shadow_wp   <= pend_wp;
        shadow_lvl  <= pend_lvl;
        shadow_user <= pend_user;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= CNT_LOAD;
    end
  end
endmodule

// File: rtl/optreg_top.sv
module optreg_top
  import optreg_pkg::*;
#(
  parameter int             NUM_SECTORS   = 12,
  parameter int             COMMIT_CYCLES = 16,
  parameter int             ADDR_W        = 8,
  parameter logic [ADDR_W-1:0] KEY_OFS    = 'h04,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 'h08
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   bus_rvalid,
  output logic                   busy,
  output logic [NUM_SECTORS-1:0] sect_wp,
  output logic                   rdp_active,
  output logic [7:0]             user_opts
);
  localparam int WP_PAD = WP_FIELD_W - NUM_SECTORS;

  logic                   locked;
  logic                   key_wr, ctrl_wr, relock, field_wr, start;
  logic [NUM_SECTORS-1:0] pend_wp, shadow_wp;
  logic [7:0]             pend_lvl, pend_user, shadow_lvl;
  logic [DATA_W-1:0]      ctrl_view;
  logic                   wdata_unused;

  assign wdata_unused = ^{bus_wdata[31:WP_LSB], bus_wdata[7:0]};

  assign key_wr   = bus_wr && (bus_addr == KEY_OFS);
  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_OFS) && !locked && !busy;
  assign relock   = ctrl_wr && bus_wdata[LOCK_BIT];
  assign field_wr = ctrl_wr && !bus_wdata[LOCK_BIT];
  assign start    = field_wr && bus_wdata[START_BIT];

  optreg_keyseq u_keyseq (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .relock   (relock),
    .locked   (locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wp   <= '1;
      pend_lvl  <= LVL_OPEN;
      pend_user <= 8'h00;
    end else if (field_wr) begin
      pend_wp   <= bus_wdata[WP_LSB +: NUM_SECTORS];
      pend_lvl  <= bus_wdata[LVL_LSB +: 8];
      pend_user <= bus_wdata[7:0] & USER_MASK;
    end
  end

  optreg_commit #(
    .NUM_SECTORS   (NUM_SECTORS),
    .COMMIT_CYCLES (COMMIT_CYCLES)
  ) u_commit (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .pend_wp     (pend_wp),
    .pend_lvl    (pend_lvl),
    .pend_user   (pend_user),
    .busy        (busy),
    .shadow_wp   (shadow_wp),
    .shadow_lvl  (shadow_lvl),
    .shadow_user (user_opts)
  );

  assign sect_wp    = ~shadow_wp;
  assign rdp_active = (shadow_lvl != LVL_OPEN);

  generate
    if (WP_PAD > 0) begin : g_pad
      assign ctrl_view = {4'h0, {WP_PAD{1'b0}}, pend_wp, pend_lvl,
                          pend_user[7:2], busy, locked};
    end else begin : g_full
      assign ctrl_view = {4'h0, pend_wp, pend_lvl, pend_user[7:2], busy, locked};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= (bus_addr == CTRL_OFS) ? ctrl_view : '0;
    end
  end
endmodule

// File: rtl/optreg_chk.sv
module optreg_chk
  import optreg_pkg::*;
#(
  parameter int                NUM_SECTORS = 12,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] KEY_OFS     = 'h04
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [DATA_W-1:0]      bus_wdata,
  input logic                   locked,
  input logic                   busy,
  input logic [NUM_SECTORS-1:0] sect_wp,
  input logic                   rdp_active
);
  a_r2_unlock_by_key: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bus_wr && bus_addr == KEY_OFS && bus_wdata == KEY_SECOND));

  a_r4_no_commit_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!locked));

  a_r8_wp_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sect_wp) |-> $fell(busy));

  a_r9_rdp_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdp_active) |-> $fell(busy));

  a_r12_no_relock_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !locked);
endmodule

bind optreg_top optreg_chk #(
  .NUM_SECTORS (NUM_SECTORS),
  .ADDR_W      (ADDR_W),
  .KEY_OFS     (KEY_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .locked     (locked),
  .busy       (busy),
  .sect_wp    (sect_wp),
  .rdp_active (rdp_active)
);

// File: tb/test_optreg_top.sv
module test_optreg_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          NSEC = 12;
  localparam int          C    = 16;
  localparam logic [7:0]  KOFS = 8'h04;
  localparam logic [7:0]  COFS = 8'h08;
  localparam logic [31:0] K1   = 32'h0819_2A3B;
  localparam logic [31:0] K2   = 32'h4C5D_6E7F;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_rvalid, busy, rdp_active;
  logic [NSEC-1:0] sect_wp;
  logic [7:0] user_opts;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  optreg_top #(.NUM_SECTORS(NSEC), .COMMIT_CYCLES(C)) i_optreg_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .busy(busy), .sect_wp(sect_wp),
    .rdp_active(rdp_active), .user_opts(user_opts)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // Tasks are entered on a falling edge and return on the next one.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_done(input int n0, input string t);
    int n = n0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    chk(t, n, C);
  endtask

  // Monitor: compares each read response against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected read response actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sect_wp", 32'(sect_wp), 32'h0);
    chk("R1 rdp_active", 32'(rdp_active), 32'h0);
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 user_opts", 32'(user_opts), 32'h0);
    rd(COFS, 32'h0FFF_AA01, "R1 ctrl reset");
    // R4 locked writes ignored
    wr(COFS, 32'h0000_5502);
    chk("R4 busy stays low", 32'(busy), 32'h0);
    rd(COFS, 32'h0FFF_AA01, "R4 fields unchanged");
    // R3 broken sequences
    wr(KOFS, K1); wr(KOFS, 32'h1234); wr(KOFS, K2);
    rd(COFS, 32'h0FFF_AA01, "R3 broken sequence stays locked");
    wr(KOFS, K1);
    rd(COFS, 32'h0FFF_AA01, "R3 first key alone stays locked");
    // R2 unlock (read between the keys is not a key write)
    wr(KOFS, K2);
    rd(COFS, 32'h0FFF_AA00, "R2 unlocked");
    // R5 R6 packing, no commit
    wr(COFS, 32'h0FF0_33FC);
    rd(COFS, 32'h0FF0_33EC, "R5 R6 packed fields");
    chk("R8 pending no effect wp", 32'(sect_wp), 32'h0);
    chk("R8 pending no effect rdp", 32'(rdp_active), 32'h0);
    // R7 commit, R12 lock ignored while busy
    wr(COFS, 32'h0FF0_33FE);
    rd(COFS, 32'h0FF0_33EE, "R7 busy bit visible");
    wr(COFS, 32'h0000_AA01);
    chk("R8 during commit wp", 32'(sect_wp), 32'h0);
    wait_done(2, "R7 busy length");
    chk("R10 wp active low", 32'(sect_wp), 32'h00F);
    chk("R9 rdp on level 33", 32'(rdp_active), 32'h1);
    chk("R7 user committed", 32'(user_opts), 32'hEC);
    rd(COFS, 32'h0FF0_33EC, "R12 lock ignored during busy");
    // R11 relock keeps fields
    wr(COFS, 32'h0000_0001);
    rd(COFS, 32'h0FF0_33ED, "R11 relock keeps fields");
    wr(COFS, 32'h0FFF_AA02);
    chk("R4 start ignored locked", 32'(busy), 32'h0);
    // R9 R10 second pattern
    wr(KOFS, K1); wr(KOFS, K2);
    wr(COFS, 32'h0FFE_AA02);
    wait_done(0, "R7 busy length 2");
    chk("R10 only sector 0", 32'(sect_wp), 32'h001);
    chk("R9 level AA open", 32'(rdp_active), 32'h0);
    wr(COFS, 32'h0FFE_AB02);
    wait_done(0, "R7 busy length 3");
    chk("R9 level AB protects", 32'(rdp_active), 32'h1);
    repeat (2) @(negedge clk);
    chk("R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule